// File: doc/BRIEF.md
# Run-Length Infrared Transmitter with Carrier Gating

This block turns a stream of run-length bytes into an infrared drive waveform. Each byte says whether the next stretch of time is a mark (pulse) or a gap (space) and how many sample periods it lasts. Software keeps two holding registers filled. The block drains them in strict alternation. Each time it takes a byte it raises an interrupt so that the emptied register can be refilled while the current byte plays out.

Marks can be chopped by a carrier. The carrier period and the polarity come from one configuration byte. The high time is derived from a duty-cycle percentage. Two drive outputs carry the same waveform, and each is enabled by one bit of a transmitter mask. Software primes both registers and pulses `start`. When a byte runs out and the next register is empty, the block stops, drives low and raises a final interrupt.

Top module: `ir_rl_tx`

## Requirements
- R1: A run-length byte carries the mark flag in bit 7 (1 = mark, 0 = space) and the duration in bits 6:0, counted in sample periods. A duration of 0 plays as 1. Each byte lasts exactly duration × sample period clocks, and a space drives the outputs low.
- R2: The sample period is `sample_us` microseconds when that value lies in 5..127, and 50 µs otherwise. One microsecond is 2 × CLKS_PER_TICK clocks.
- R3: `wr_sel` picks which holding register a write fills. After `start`, register 0 is played first and the registers then alternate 1, 0, 1, and so on. A `start` seen while busy has no effect.
- R4: Consecutive bytes of the same type join with no gap or glitch at the boundary.
- R5: When the carrier is active, a mark is gated so that it is high for the first H ticks of every P-tick carrier cycle. P is `car_prd[6:0]` and one tick is 0.5 µs (CLKS_PER_TICK clocks). The carrier phase restarts at each byte. `car_prd[7]` = 1 inverts the carrier.
- R6: H = P / (100 / duty), using integer division, with a minimum of 1. A `car_duty` outside 1..99 is taken as 50.
- R7: With `car_en` low, or with P = 0, a mark is a steady high.
- R8: The transmitter mask resets to 2'b11. A mask write is accepted only if the value is nonzero and bits 7:2 are zero. `tx_out[i]` is the waveform ANDed with mask bit i.
- R9: `irq` is set whenever a holding register is consumed. It stays set until software writes 1 to `irq_clr`, and a new set wins over a clear in the same cycle.
- R10: When a byte ends and the next register is empty, or when `start` finds register 0 empty, the outputs go low, `busy` falls and `irq` is set.
- R11: After reset the outputs are low and `irq` and `busy` are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for a holding register |
| wr_sel | input | 1 | Holding register selected by the write |
| wr_data | input | 8 | Run-length byte: bit 7 mark flag, bits 6:0 duration |
| start | input | 1 | Begin playing from register 0 |
| sample_us | input | 7 | Sample period in microseconds |
| car_en | input | 1 | Carrier enable |
| car_prd | input | 8 | Bit 7 polarity, bits 6:0 carrier period in 0.5 µs ticks |
| car_duty | input | 7 | Carrier duty cycle in percent |
| mask_wr | input | 1 | Transmitter mask write strobe |
| mask_data | input | 8 | Proposed transmitter mask |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| tx_out | output | 2 | Drive outputs |
| irq | output | 1 | Refill and completion interrupt |
| busy | output | 1 | Transmission in progress |

## Verification
A cycle-exact scoreboard targets the following errors:
- An off-by-one in the sample counter would stretch or shorten every byte by a clock.
- A one-cycle bubble at a byte boundary would show up as a dropped sample in a long mark split across two bytes.
- A carrier phase that does not restart at each byte would shift the chopped mark.
- A high-time calculation without the minimum of 1 would silence a 1 % duty carrier, and one that skips the duty fallback would divide by zero.
- A start that re-arms while busy would replay register 0.
- A mask that takes invalid writes would silence both outputs.
- An out-of-range sample period that is not replaced by the default would give a byte of the wrong length.

// File: rtl/ir_rl_tx.sv
module ir_rl_tx #(
  parameter int CLKS_PER_TICK = 24,
  parameter int DEF_SAMPLE_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       start,
  input  logic [6:0] sample_us,
  input  logic       car_en,
  input  logic [7:0] car_prd,
  input  logic [6:0] car_duty,
  input  logic       mask_wr,
  input  logic [7:0] mask_data,
  input  logic       irq_clr,
  output logic [1:0] tx_out,
  output logic       irq,
  output logic       busy
);
  localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam int SW = $clog2(127 * 2 * CLKS_PER_TICK + 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(CLKS_PER_TICK - 1);

  logic [7:0]    hold_q [2];
  logic [1:0]    full_q;
  logic          sel_q, busy_q, pulse_q, irq_q;
  logic [6:0]    left_q, ph_q;
  logic [SW-1:0] stmr_q;
  logic [CW-1:0] pre_q;
  logic [1:0]    mask_q;

  logic [6:0]    samp_eff, duty_eff, ratio, hi_raw, hi_t, per;
  logic [SW-1:0] samp_clks;
  logic          stick, need, load, fin, car_on, carr, lvl;

  assign samp_eff  = (sample_us >= 7'd5) ? sample_us : 7'(DEF_SAMPLE_US);
  assign samp_clks = SW'(samp_eff) * SW'(2 * CLKS_PER_TICK);
  assign stick     = busy_q && (left_q != 7'd0) && (stmr_q == samp_clks - SW'(1));
  assign need      = busy_q && ((left_q == 7'd0) || (stick && left_q == 7'd1));
  assign load      = need && full_q[sel_q];
  assign fin       = need && !full_q[sel_q];

  assign per      = car_prd[6:0];
  assign duty_eff = (car_duty == 7'd0 || car_duty >= 7'd100) ? 7'd50 : car_duty;
  assign ratio    = 7'd100 / duty_eff;
  assign hi_raw   = per / ratio;
  assign hi_t     = (hi_raw == 7'd0) ? 7'd1 : hi_raw;
  assign car_on   = car_en && (per != 7'd0);
  assign carr     = (ph_q < hi_t) ^ car_prd[7];
  assign lvl      = busy_q && pulse_q && (car_on ? carr : 1'b1);

  assign tx_out = {2{lvl}} & mask_q;
  assign irq    = irq_q;
  assign busy   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sel_q   <= 1'b0;
      pulse_q <= 1'b0;
      left_q  <= '0;
      stmr_q  <= '0;
      pre_q   <= '0;
      ph_q    <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      sel_q   <= 1'b0;
      pulse_q <= 1'b0;
      left_q  <= '0;
    end else if (load) begin
      left_q  <= (hold_q[sel_q][6:0] == 7'd0) ? 7'd1 : hold_q[sel_q][6:0];
      pulse_q <= hold_q[sel_q][7];
      sel_q   <= ~sel_q;
      stmr_q  <= '0;
      pre_q   <= '0;
      ph_q    <= '0;
    end else if (fin) begin
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
      left_q  <= '0;
    end else if (busy_q) begin
      if (stick) begin
        stmr_q <= '0;
        left_q <= left_q - 7'd1;
      end else begin
        stmr_q <= stmr_q + SW'(1);
      end
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        ph_q  <= (ph_q >= per - 7'd1) ? 7'd0 : ph_q + 7'd1;
      end else begin
        pre_q <= pre_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= '0;
      hold_q[0] <= '0;
      hold_q[1] <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (wr_en && (wr_sel == 1'(i))) begin
          full_q[i] <= 1'b1;
          hold_q[i] <= wr_data;
        end else if (load && (sel_q == 1'(i))) begin
          full_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      mask_q <= 2'b11;
    end else begin
      if (load || fin)  irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (mask_wr && (mask_data != 8'd0) && (mask_data[7:2] == 6'd0))
        mask_q <= mask_data[1:0];
    end
  end
endmodule

// File: rtl/ir_rl_tx_chk.sv
module ir_rl_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic [1:0] tx_out,
  input logic [1:0] mask_q,
  input logic       pulse_q,
  input logic       irq,
  input logic       irq_clr,
  input logic       mask_wr,
  input logic [7:0] mask_data
);
  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_out == 2'b00);
  assert_space_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pulse_q) |-> tx_out == 2'b00);
  assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out & ~mask_q) == 2'b00);
  assert_bad_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && (mask_data == 8'd0 || mask_data[7:2] != 6'd0)) |=> $stable(mask_q));
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind ir_rl_tx ir_rl_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .tx_out(tx_out),
  .mask_q(mask_q), .pulse_q(pulse_q), .irq(irq), .irq_clr(irq_clr),
  .mask_wr(mask_wr), .mask_data(mask_data)
);

// File: tb/tb_ir_rl_tx.sv
module tb_ir_rl_tx;
  localparam int CLK_NS = 10;
  localparam int CPT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, start = 0, car_en = 0, mask_wr = 0, irq_clr = 0;
  logic [7:0] wr_data = 0, car_prd = 0, mask_data = 0;
  logic [6:0] sample_us = 7'd5, car_duty = 7'd50;
  logic [1:0] tx_out;
  logic irq, busy;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0] q_exp[$];
  bit q_chk[$];
  string q_tag[$];

  int b_S = 5 * 2 * CPT, b_P = 0, b_H = 1;
  bit b_on = 0, b_pol = 0;
  logic [1:0] b_mask = 2'b11;

  ir_rl_tx #(.CLKS_PER_TICK(CPT)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .sample_us(sample_us), .car_en(car_en), .car_prd(car_prd),
    .car_duty(car_duty), .mask_wr(mask_wr), .mask_data(mask_data),
    .irq_clr(irq_clr), .tx_out(tx_out), .irq(irq), .busy(busy)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [1:0] e;
      bit c;
      string t;
      e = q_exp.pop_front();
      c = q_chk.pop_front();
      t = q_tag.pop_front();
      if (c) check(t, {30'd0, tx_out}, {30'd0, e});
    end
  end

  task automatic set_carrier(bit en, logic [7:0] prd, logic [6:0] duty);
    int d;
    @(posedge clk); #1;
    car_en = en; car_prd = prd; car_duty = duty;
    d = (duty == 0 || duty >= 100) ? 50 : int'(duty);
    b_P = int'(prd[6:0]);
    b_pol = prd[7];
    b_on = en && (b_P != 0);
    b_H = b_P / (100 / d);
    if (b_H == 0) b_H = 1;
  endtask

  task automatic set_sample(logic [6:0] us);
    @(posedge clk); #1;
    sample_us = us;
    b_S = ((us >= 5) ? int'(us) : 50) * 2 * CPT;
  endtask

  task automatic write_mask(logic [7:0] v);
    @(posedge clk); #1; mask_wr = 1; mask_data = v;
    @(posedge clk); #1; mask_wr = 0;
    if (v != 0 && v[7:2] == 0) b_mask = v[1:0];
  endtask

  task automatic write_reg(bit s, logic [7:0] v);
    @(posedge clk); #1; wr_en = 1; wr_sel = s; wr_data = v;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic push_byte(string tag, logic [7:0] b);
    int dur;
    dur = (b[6:0] == 0) ? 1 : int'(b[6:0]);
    for (int c = 0; c < dur * b_S; c++) begin
      bit lv;
      if (!b[7]) lv = 0;
      else if (!b_on) lv = 1;
      else lv = (((c / CPT) % b_P) < b_H) ^ b_pol;
      q_exp.push_back({lv, lv} & b_mask);
      q_chk.push_back(1);
      q_tag.push_back(tag);
    end
  endtask

  task automatic play(string tag, int n, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    write_reg(0, b0);
    write_reg(1, b1);
    @(posedge clk); #1;
    for (int k = 0; k < 2; k++) begin
      q_exp.push_back(2'b00); q_chk.push_back(0); q_tag.push_back(tag);
    end
    push_byte(tag, b0);
    push_byte(tag, b1);
    if (n == 3) push_byte(tag, b2);
    for (int k = 0; k < 4; k++) begin
      q_exp.push_back(2'b00); q_chk.push_back(1); q_tag.push_back(tag);
    end
    start = 1;
    @(posedge clk); #1; start = 0;
    if (n == 3) begin
      while (!irq) @(negedge clk);
      @(posedge clk); #1;
      irq_clr = 1; wr_en = 1; wr_sel = 0; wr_data = b2; start = 1;
      @(posedge clk); #1;
      irq_clr = 0; wr_en = 0; start = 0;
    end
    while (q_exp.size() > 0) @(negedge clk);
    check({tag, " R10 busy low after last byte"}, {31'd0, busy}, 32'd0);
    check({tag, " R10 completion irq"}, {31'd0, irq}, 32'd1);
    @(posedge clk); #1; irq_clr = 1;
    @(posedge clk); #1; irq_clr = 0;
    @(negedge clk);
    check({tag, " R9 irq cleared by write-one"}, {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R11 tx_out after reset", {30'd0, tx_out}, 32'd0);
    check("R11 irq after reset", {31'd0, irq}, 32'd0);
    check("R11 busy after reset", {31'd0, busy}, 32'd0);

    set_carrier(0, 8'd4, 7'd50);
    play("R1 plain mark/space", 2, 8'h82, 8'h03, 8'h00);

    set_carrier(1, 8'd4, 7'd50);
    play("R5 carrier 50%", 2, 8'h83, 8'h02, 8'h00);
    set_carrier(1, 8'h84, 7'd50);
    play("R5 inverted carrier", 2, 8'h82, 8'h01, 8'h00);

    set_carrier(1, 8'd8, 7'd25);
    play("R6 duty 25", 2, 8'h82, 8'h01, 8'h00);
    set_carrier(1, 8'd4, 7'd1);
    play("R6 duty 1 min high", 2, 8'h82, 8'h01, 8'h00);
    set_carrier(1, 8'd6, 7'd0);
    play("R6 duty 0 fallback", 2, 8'h83, 8'h01, 8'h00);

    set_carrier(1, 8'd0, 7'd50);
    play("R7 zero period steady", 2, 8'h82, 8'h01, 8'h00);
    set_carrier(0, 8'd4, 7'd50);

    write_mask(8'h01);
    write_mask(8'h04);
    write_mask(8'h00);
    play("R8 mask one output", 2, 8'h81, 8'h01, 8'h00);
    write_mask(8'h03);

    set_sample(7'd3);
    play("R2 default sample period", 2, 8'h81, 8'h00, 8'h00);
    set_sample(7'd7);
    play("R1 zero duration as one", 2, 8'h80, 8'h02, 8'h00);
    set_sample(7'd5);

    play("R4 split long mark", 2, 8'h85, 8'h83, 8'h00);

    set_carrier(1, 8'd4, 7'd50);
    play("R3 refill alternation", 3, 8'h82, 8'h02, 8'h83);
    set_carrier(0, 8'd4, 7'd50);

    @(posedge clk); #1; start = 1;
    @(posedge clk); #1; start = 0;
    repeat (3) @(negedge clk);
    check("R10 empty start busy", {31'd0, busy}, 32'd0);
    check("R10 empty start irq", {31'd0, irq}, 32'd1);
    check("R10 empty start output", {30'd0, tx_out}, 32'd0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule